// File: doc/BRIEF.md
# Dual-Pulse Up/Down Counter

A 4-bit binary counter driven by two separate count request lines instead of a direction pin and a shared clock. One line asks for an increment and the other asks for a decrement. Both lines rest high and pulse low. Every register in the block runs on one fast system clock. The two request lines are treated as asynchronous inputs: each passes through a two-stage synchronizer.

A small state machine follows the synchronized lines. It records which line fell first, which latches the direction. It merges the two lines so that the trailing (rising) edge of a pulse produces exactly one step in the latched direction. The counter also has an asynchronous clear and a parallel load. It has two active-low terminal flags, which a following stage can use to see an imminent wrap.

State machine states:
- `ST_IDLE`: both lines high.
- `ST_UP_LOW`: an increment pulse is in progress.
- `ST_DN_LOW`: a decrement pulse is in progress.
- `ST_BOTH`: both lines low, which is an illegal condition.

Transitions:
- idle→up-low when only the increment line falls.
- idle→dn-low when only the decrement line falls.
- idle→both when both lines fall.
- up-low→idle (with an increment step) when the increment line rises.
- dn-low→idle (with a decrement step) when the decrement line rises.
- up-low→both and dn-low→both when the other line also falls.
- both→idle, with no step, only once both lines are high again.

Top module: `pulse_updown_counter`

## Requirements
- R1: While `clr` is high the count is 0 at once, without waiting for a clock edge, whatever `load` and the count lines do.
- R2: While `load` is high (and `clr` low), each clock edge copies `din` into the count. Count pulses completed during load are discarded.
- R3: A low pulse on `up_n` (with `dn_n` held high) raises the count by exactly 1. The change appears within 3 system clocks after the rising edge of `up_n`. The count does not change while `up_n` is low.
- R4: A low pulse on `dn_n` (with `up_n` held high) lowers the count by exactly 1, with the same timing as R3.
- R5: Counting up from 15 gives 0, and counting down from 0 gives 15.
- R6: With both count lines high and `load` low, the count holds its value across any number of clocks.
- R7: If both count lines are low at the same time, no step happens. This holds for that pulse even when one line rises first. Counting resumes normally after both lines have returned high.
- R8: `carry_n` is 0 exactly while the count is 15 and the synchronized `up_n` is low; otherwise it is 1.
- R9: `borrow_n` is 0 exactly while the count is 0 and the synchronized `dn_n` is low; otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all registers use its rising edge |
| clr | input | 1 | Asynchronous clear, active high; also the block reset |
| load | input | 1 | Synchronous parallel load, active high |
| din | input | 4 | Value copied into the count during load |
| up_n | input | 1 | Increment request, idle high, pulses low, asynchronous |
| dn_n | input | 1 | Decrement request, idle high, pulses low, asynchronous |
| count | output | 4 | Current count value |
| carry_n | output | 1 | Active-low terminal flag for counting up |
| borrow_n | output | 1 | Active-low terminal flag for counting down |

## Verification
Two functions can fall in the same cycle: a load and the step produced by the trailing edge of a count pulse. The bench provokes this by holding `load` high across the whole of an increment pulse, including the synchronizer delay after the rising edge. It then judges the count against `din` both during the load and after load is released; no step may leak through. The same collision occurs with clear: `clr` is raised together with `load`, and the count must read 0.

// File: rtl/pud_pkg.sv
package pud_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_UP_LOW = 2'd1,
        ST_DN_LOW = 2'd2,
        ST_BOTH   = 2'd3
    } pud_state_e;

    localparam int unsigned LINE_UP = 0;
    localparam int unsigned LINE_DN = 1;
    localparam int unsigned N_LINES = 2;

endpackage

// File: rtl/pud_sync.sv
module pud_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] sync_out
);

    localparam logic [LINES-1:0] IDLE_LEVEL = {LINES{1'b1}};

    logic [LINES-1:0] stage_q [STAGES];

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            stage_q[0] <= IDLE_LEVEL;
        end else begin
            stage_q[0] <= async_in;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or posedge clr) begin
            if (clr) begin
                stage_q[s] <= IDLE_LEVEL;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pud_dir_fsm.sv
module pud_dir_fsm
    import pud_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       up_s,
    input  logic       dn_s,
    output logic       step_up,
    output logic       step_dn,
    output pud_state_e state_o
);

    pud_state_e state_q;
    pud_state_e state_d;

    // State register
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and step outputs
    always_comb begin
        state_d = state_q;
        step_up = 1'b0;
        step_dn = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!up_s && !dn_s) begin
                    state_d = ST_BOTH;
                end else if (!up_s) begin
                    state_d = ST_UP_LOW;
                end else if (!dn_s) begin
                    state_d = ST_DN_LOW;
                end
            end
            ST_UP_LOW: begin
                if (up_s) begin
                    step_up = 1'b1;
                    state_d = dn_s ? ST_IDLE : ST_DN_LOW;
                end else if (!dn_s) begin
                    state_d = ST_BOTH;
                end
            end
            ST_DN_LOW: begin
                if (dn_s) begin
                    step_dn = 1'b1;
                    state_d = up_s ? ST_IDLE : ST_UP_LOW;
                end else if (!up_s) begin
                    state_d = ST_BOTH;
                end
            end
            ST_BOTH: begin
                if (up_s && dn_s) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/pud_core.sv
module pud_core #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             up_active,
    input  logic             dn_active,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam logic [WIDTH-1:0] TOP_VAL  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO_VAL = '0;
    localparam logic [WIDTH-1:0] ONE_VAL  = WIDTH'(1);

    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] count_d;

    always_comb begin
        count_d = count_q;
        if (load) begin
            count_d = din;
        end else if (step_up) begin
            count_d = count_q + ONE_VAL;
        end else if (step_dn) begin
            count_d = count_q - ONE_VAL;
        end
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            count_q <= ZERO_VAL;
        end else begin
            count_q <= count_d;
        end
    end

    assign count    = count_q;
    assign carry_n  = ~((count_q == TOP_VAL) && up_active);
    assign borrow_n = ~((count_q == ZERO_VAL) && dn_active);

endmodule

// File: rtl/pulse_updown_counter.sv
module pulse_updown_counter
    import pud_pkg::*;
#(
    parameter int unsigned WIDTH       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    input  logic             up_n,
    input  logic             dn_n,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic               up_s;
    logic               dn_s;
    logic               step_up_w;
    logic               step_dn_w;
    pud_state_e         fsm_state;

    assign raw_lines[LINE_UP] = up_n;
    assign raw_lines[LINE_DN] = dn_n;

    pud_sync #(
        .LINES  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .clr      (clr),
        .async_in (raw_lines),
        .sync_out (sync_lines)
    );

    assign up_s = sync_lines[LINE_UP];
    assign dn_s = sync_lines[LINE_DN];

    pud_dir_fsm u_fsm (
        .clk     (clk),
        .clr     (clr),
        .up_s    (up_s),
        .dn_s    (dn_s),
        .step_up (step_up_w),
        .step_dn (step_dn_w),
        .state_o (fsm_state)
    );

    pud_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk       (clk),
        .clr       (clr),
        .load      (load),
        .din       (din),
        .step_up   (step_up_w),
        .step_dn   (step_dn_w),
        .up_active (~up_s),
        .dn_active (~dn_s),
        .count     (count),
        .carry_n   (carry_n),
        .borrow_n  (borrow_n)
    );

endmodule

// File: rtl/pud_checker.sv
module pud_checker #(
    parameter int unsigned WIDTH = 4
) (
    input logic             clk,
    input logic             clr,
    input logic             load,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] count,
    input logic             carry_n,
    input logic             borrow_n,
    input logic             step_up,
    input logic             step_dn,
    input logic [1:0]       state
);

    always @(negedge clk) begin
        if (clr) begin
            AST_CLR_ZERO: assert (count == '0); // R1
        end
    end

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (clr)
        load |=> count == $past(din)); // R2

    AST_STEP_UP: assert property (@(posedge clk) disable iff (clr)
        (step_up && !load) |=> count == WIDTH'($past(count) + 1'b1)); // R3

    AST_STEP_DN: assert property (@(posedge clk) disable iff (clr)
        (step_dn && !load) |=> count == WIDTH'($past(count) - 1'b1)); // R4

    AST_HOLD: assert property (@(posedge clk) disable iff (clr)
        (!step_up && !step_dn && !load) |=> $stable(count)); // R6

    AST_BOTH_NO_STEP: assert property (@(posedge clk) disable iff (clr)
        (state == 2'd3) |-> !(step_up || step_dn)); // R7

    AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (clr)
        !carry_n |-> count == {WIDTH{1'b1}}); // R8

    AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (clr)
        !borrow_n |-> count == '0); // R9

endmodule

bind pulse_updown_counter pud_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .clr      (clr),
    .load     (load),
    .din      (din),
    .count    (count),
    .carry_n  (carry_n),
    .borrow_n (borrow_n),
    .step_up  (step_up_w),
    .step_dn  (step_dn_w),
    .state    (fsm_state)
);

// File: tb/pulse_updown_counter_test.sv
module pulse_updown_counter_test;

    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       load = 1'b0;
    logic [3:0] din = 4'd0;
    logic       up_n = 1'b1;
    logic       dn_n = 1'b1;
    logic [3:0] count;
    logic       carry_n;
    logic       borrow_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pulse_updown_counter uut (
        .clk      (clk),
        .clr      (clr),
        .load     (load),
        .din      (din),
        .up_n     (up_n),
        .dn_n     (dn_n),
        .count    (count),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    // vector: {op[1:0], data[3:0], expected[3:0]}; op 0=load 1=up 2=down 3=idle
    localparam int NVEC = 12;
    localparam logic [9:0] VEC [NVEC] = '{
        {2'd0, 4'd13, 4'd13},
        {2'd1, 4'd0,  4'd14},
        {2'd1, 4'd0,  4'd15},
        {2'd1, 4'd0,  4'd0},
        {2'd2, 4'd0,  4'd15},
        {2'd2, 4'd0,  4'd14},
        {2'd3, 4'd0,  4'd14},
        {2'd0, 4'd0,  4'd0},
        {2'd2, 4'd0,  4'd15},
        {2'd1, 4'd0,  4'd0},
        {2'd1, 4'd0,  4'd1},
        {2'd2, 4'd0,  4'd0}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_up(input int low_cycles);
        up_n = 1'b0;
        cyc(low_cycles);
        up_n = 1'b1;
        cyc(4);
    endtask

    task automatic pulse_dn(input int low_cycles);
        dn_n = 1'b0;
        cyc(low_cycles);
        dn_n = 1'b1;
        cyc(4);
    endtask

    task automatic do_load(input logic [3:0] v);
        din  = v;
        load = 1'b1;
        cyc(1);
        load = 1'b0;
        cyc(1);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev_op;
        prev_op = 2'd3;
        // reset state, R1
        cyc(3);
        chk("R1 reset count", count, 4'd0);
        chk("R8 reset carry_n", {3'b0, carry_n}, 4'd1);
        chk("R9 reset borrow_n", {3'b0, borrow_n}, 4'd1);
        clr = 1'b0;
        cyc(2);

        // vector walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            op = VEC[i][9:8];
            if ((op == 2'd1 && prev_op == 2'd2) || (op == 2'd2 && prev_op == 2'd1))
                cyc(8); // longer spacing on direction change
            unique case (op)
                2'd0: do_load(VEC[i][7:4]);
                2'd1: pulse_up(3);
                2'd2: pulse_dn(3);
                2'd3: cyc(20);
                default: ;
            endcase
            chk($sformatf("R3/R4/R5/R2 vec %0d", i), count, VEC[i][3:0]);
            if (op != 2'd3 && op != 2'd0) prev_op = op;
        end

        // R8 carry and R3 no change while low
        do_load(4'd15);
        up_n = 1'b0;
        cyc(4);
        chk("R8 carry_n low at 15", {3'b0, carry_n}, 4'd0);
        chk("R3 no change while low", count, 4'd15);
        up_n = 1'b1;
        cyc(4);
        chk("R5 wrap up", count, 4'd0);
        chk("R8 carry_n released", {3'b0, carry_n}, 4'd1);
        cyc(8);

        // R9 borrow
        dn_n = 1'b0;
        cyc(4);
        chk("R9 borrow_n low at 0", {3'b0, borrow_n}, 4'd0);
        dn_n = 1'b1;
        cyc(4);
        chk("R5 wrap down", count, 4'd15);
        chk("R9 borrow_n released", {3'b0, borrow_n}, 4'd1);
        cyc(4);

        // R7 both low
        do_load(4'd5);
        up_n = 1'b0;
        cyc(4);
        dn_n = 1'b0;
        cyc(4);
        up_n = 1'b1;
        cyc(4);
        chk("R7 no step after up rise in both-low", count, 4'd5);
        dn_n = 1'b1;
        cyc(4);
        chk("R7 no step after both high", count, 4'd5);
        cyc(8);
        pulse_up(3);
        chk("R7 counting resumes", count, 4'd6);
        cyc(4);

        // R6 hold
        cyc(30);
        chk("R6 hold idle", count, 4'd6);

        // R2 load collides with step
        din  = 4'd3;
        load = 1'b1;
        up_n = 1'b0;
        cyc(4);
        up_n = 1'b1;
        cyc(5);
        chk("R2 count during load", count, 4'd3);
        load = 1'b0;
        cyc(3);
        chk("R2 step discarded", count, 4'd3);

        // R1 async clear away from edge, priority over load
        @(posedge clk);
        #1;
        clr = 1'b1;
        #0.5;
        chk("R1 async clear", count, 4'd0);
        din  = 4'd7;
        load = 1'b1;
        cyc(2);
        chk("R1 clear over load", count, 4'd0);
        clr  = 1'b0;
        load = 1'b0;
        cyc(2);
        chk("R1 stays 0 after clear", count, 4'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule